// File: doc/BRIEF.md
# Strobed Digit Latch and Glyph Decoder

This block is the parallel-entry front end of an eight-digit triplexed LCD driver. A host puts a digit address, a four-bit character code and two annunciator bits on the input pins. It then pulses an active-low strobe. When the strobe returns high, the block takes the word that was present while the strobe was low. It turns that word into the nine segment bits of one digit and stores them in a per-digit display memory. A downstream waveform generator reads that memory through a flat combinational port.

The strobe is asynchronous to the system clock. It passes through a two-flop synchroniser, and the data pins are delayed in step with it. A one-shot enable of exactly one clock commits the decoded word to memory. After each accepted strobe a busy window of `BUSY_GAP` clocks follows, and a strobe that ends inside that window is dropped. Two static strap pins select the behaviour. One chooses the font: a hexadecimal set, or a set of ten digits plus dash, E, H, L, P and blank. The other chooses where the two annunciators sit on the backplanes.

Top module: `lcd_strobe_front`

## Requirements
- R1: After reset every stored bit of every digit is 0, so all segments are off.
- R2: An accepted write changes only the digit whose index equals the address. Every other digit keeps its nine bits.
- R3: With `font_hex_i`=1, codes 0..15 give the glyphs 0-9, A, b, C, d, E, F. In {g,f,e,d,c,b,a} notation these are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).
- R4: With `font_hex_i`=0, codes 0..9 give the same digits as R3. Codes 10..15 give dash (40), E (79), H (76), L (38), P (73) and blank (00).
- R5: With `ann_split_i`=0 the stored word is {an2,e,f,an1,c,b,d,g,a}, bit 8 down to bit 0. Here an1 is `ann_i[0]` and an2 is `ann_i[1]`, and each annunciator is lit when its bit is 1.
- R6: With `ann_split_i`=1 the stored word is {e,f,an2,an1,c,b,d,g,a}, bit 8 down to bit 0, with the same annunciator bits as R5.
- R7: If a strobe's rising edge is detected within `BUSY_GAP` clocks of the previous accepted one, the strobe is ignored and the memory is unchanged.
- R8: The captured word is the last one sampled while the strobe was low. Input changes at or after the rising edge of the strobe have no effect.
- R9: Each accepted strobe produces a write enable exactly one clock long. The write is visible on `seg_mem_o` no later than four clock edges after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n_i | input | 1 | Active-low write strobe; its rising edge commits the word |
| dig_addr_i | input | 3 | Digit index |
| code_i | input | 4 | Character code |
| ann_i | input | 2 | Annunciator bits, [0]=an1, [1]=an2 |
| font_hex_i | input | 1 | 1 selects the hexadecimal font, 0 the dash/E/H/L/P/blank font |
| ann_split_i | input | 1 | Annunciator placement strap, see R5 and R6 |
| seg_mem_o | output | 72 | Display memory, digit n in bits [9n+8:9n] |

## Verification
The bench sweeps every code under both fonts and both placements, rotating the target address and the annunciator pair. After each write it compares the whole 72-bit memory, so a write that leaks into a neighbouring digit or swaps two segment bits is caught. Each strobe inverts all input pins at the same moment it rises. A design that sampled one clock late would store the inverted word. A second strobe is placed inside the busy window; a design with no window, or too short a window, would overwrite the digit. A later strobe outside the window must land, which catches a window that never reopens.

// File: rtl/lcd_front_pkg.sv
package lcd_front_pkg;
  localparam int SEG_LINES  = 3;
  localparam int BACKPLANES = 3;
  localparam int WORD_W     = SEG_LINES * BACKPLANES;
  localparam int CODE_W     = 4;
  localparam int ANN_W      = 2;

  typedef logic [WORD_W-1:0] seg_word_t;
  // seven segments packed as {g,f,e,d,c,b,a}
  typedef logic [6:0] glyph_t;
endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync #(
  parameter int BUS_W    = 11,
  parameter int BUSY_GAP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_n_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             wr_pulse_o,
  output logic [BUS_W-1:0] bus_o
);
  localparam int CNT_W = $clog2(BUSY_GAP + 1);

  logic             s1_q, s2_q, s3_q;
  logic [BUS_W-1:0] d1_q, d2_q, d3_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, accept;
  logic [BUS_W-1:0] cap_q, cap_d;

  always_comb begin
    accept = s2_q & ~s3_q & (cnt_q == '0);
    if (accept)
      cnt_d = CNT_W'(BUSY_GAP);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
    cap_d = accept ? d3_q : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      s3_q  <= 1'b1;
      d1_q  <= '0;
      d2_q  <= '0;
      d3_q  <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      s1_q  <= strobe_n_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      d1_q  <= bus_i;
      d2_q  <= d1_q;
      d3_q  <= d2_q;
      cnt_q <= cnt_d;
      en_q  <= accept;
      cap_q <= cap_d;
    end
  end

  assign wr_pulse_o = en_q;
  assign bus_o      = cap_q;

  assert_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> !en_q);
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q != '0));
endmodule

// File: rtl/lcd_glyph_decode.sv
module lcd_glyph_decode
  import lcd_front_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [ANN_W-1:0]  ann_i,
  input  logic              font_hex_i,
  input  logic              ann_split_i,
  output seg_word_t         word_o
);
  glyph_t g;
  glyph_t g_hex_hi, g_alt_hi;

  always_comb begin
    case (code_i[2:0])
      3'd2:    g_alt_hi = 7'h40;
      3'd3:    g_alt_hi = 7'h79;
      3'd4:    g_alt_hi = 7'h76;
      3'd5:    g_alt_hi = 7'h38;
      3'd6:    g_alt_hi = 7'h73;
      3'd7:    g_alt_hi = 7'h00;
      default: g_alt_hi = 7'h00;
    endcase
    case (code_i[2:0])
      3'd2:    g_hex_hi = 7'h77;
      3'd3:    g_hex_hi = 7'h7C;
      3'd4:    g_hex_hi = 7'h39;
      3'd5:    g_hex_hi = 7'h5E;
      3'd6:    g_hex_hi = 7'h79;
      3'd7:    g_hex_hi = 7'h71;
      default: g_hex_hi = 7'h00;
    endcase
    case (code_i)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7D;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h6F;
      default: g = font_hex_i ? g_hex_hi : g_alt_hi;
    endcase
  end

  // line 0 carries a/g/d, line 1 b/c/an1, line 2 the f/e/an2 group
  always_comb begin
    word_o[0] = g[0];
    word_o[1] = g[6];
    word_o[2] = g[3];
    word_o[3] = g[1];
    word_o[4] = g[2];
    word_o[5] = ann_i[0];
    if (ann_split_i) begin
      word_o[6] = ann_i[1];
      word_o[7] = g[5];
      word_o[8] = g[4];
    end else begin
      word_o[6] = g[5];
      word_o[7] = g[4];
      word_o[8] = ann_i[1];
    end
  end
endmodule

// File: rtl/lcd_digit_store.sv
module lcd_digit_store
  import lcd_front_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int ADDR_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  seg_word_t                    wr_word_i,
  output logic [NUM_DIGITS*WORD_W-1:0] mem_flat_o
);
  logic [NUM_DIGITS-1:0] sel;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    seg_word_t word_q, word_d;
    assign sel[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
    always_comb word_d = sel[i] ? wr_word_i : word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign mem_flat_o[i*WORD_W +: WORD_W] = word_q;
  end

  assert_single_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mem_flat_o));
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_flat_o == '0));
endmodule

// File: rtl/lcd_strobe_front.sv
module lcd_strobe_front
  import lcd_front_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int ADDR_W     = 3,
  parameter int BUSY_GAP   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe_n_i,
  input  logic [ADDR_W-1:0]            dig_addr_i,
  input  logic [CODE_W-1:0]            code_i,
  input  logic [ANN_W-1:0]             ann_i,
  input  logic                         font_hex_i,
  input  logic                         ann_split_i,
  output logic [NUM_DIGITS*WORD_W-1:0] seg_mem_o
);
  localparam int BUS_W = 2 + ADDR_W + ANN_W + CODE_W;

  logic             rst_m_q, rst_q;
  logic [BUS_W-1:0] bus_in, bus_cap;
  logic             wr_pulse;
  logic [ADDR_W-1:0] cap_addr;
  logic [CODE_W-1:0] cap_code;
  logic [ANN_W-1:0]  cap_ann;
  logic             cap_hex, cap_split;
  seg_word_t        dec_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q   <= rst_m_q;
    end
  end

  assign bus_in = {font_hex_i, ann_split_i, dig_addr_i, ann_i, code_i};
  assign {cap_hex, cap_split, cap_addr, cap_ann, cap_code} = bus_cap;

  lcd_strobe_sync #(.BUS_W(BUS_W), .BUSY_GAP(BUSY_GAP)) u_sync (
    .clk        (clk),
    .rst_n      (rst_q),
    .strobe_n_i (strobe_n_i),
    .bus_i      (bus_in),
    .wr_pulse_o (wr_pulse),
    .bus_o      (bus_cap)
  );

  lcd_glyph_decode u_dec (
    .code_i      (cap_code),
    .ann_i       (cap_ann),
    .font_hex_i  (cap_hex),
    .ann_split_i (cap_split),
    .word_o      (dec_word)
  );

  lcd_digit_store #(.NUM_DIGITS(NUM_DIGITS), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_q),
    .wr_en_i    (wr_pulse),
    .wr_addr_i  (cap_addr),
    .wr_word_i  (dec_word),
    .mem_flat_o (seg_mem_o)
  );

  assert_blank_code_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (!cap_hex && cap_code == 4'd15) |->
      ((dec_word & ~(cap_split ? 9'h060 : 9'h120)) == '0));
endmodule

// File: tb/tb_lcd_strobe_front.sv
module tb_lcd_strobe_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_n;
  logic [2:0]  addr;
  logic [3:0]  code;
  logic [1:0]  ann;
  logic        fhex, split;
  logic [71:0] mem;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [8:0] model [8];

  always #4 clk = ~clk;

  lcd_strobe_front dut (
    .clk(clk), .rst_n(rst_n), .strobe_n_i(strobe_n), .dig_addr_i(addr),
    .code_i(code), .ann_i(ann), .font_hex_i(fhex), .ann_split_i(split),
    .seg_mem_o(mem)
  );

  function automatic logic [6:0] glyph(input logic [3:0] c, input logic h);
    logic [6:0] hx [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                            7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    logic [6:0] cb [6]  = '{7'h40,7'h79,7'h76,7'h38,7'h73,7'h00};
    if (h || c < 10) return hx[c];
    return cb[c - 10];
  endfunction

  function automatic logic [8:0] expect_word(input logic [3:0] c, input logic [1:0] a,
                                             input logic h, input logic s);
    logic [6:0] g = glyph(c, h);
    // g = {g,f,e,d,c,b,a}
    if (s) return {g[4], g[5], a[1], a[0], g[2], g[1], g[3], g[6], g[0]};
    return {a[1], g[4], g[5], a[0], g[2], g[1], g[3], g[6], g[0]};
  endfunction

  function automatic logic [71:0] model_flat();
    logic [71:0] f;
    for (int i = 0; i < 8; i++) f[i*9 +: 9] = model[i];
    return f;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe held low three clocks; all pins inverted as it rises (R8)
  task automatic pulse(input logic [2:0] a, input logic [3:0] c, input logic [1:0] n,
                       input logic h, input logic s, input int low_cycles);
    @(negedge clk);
    addr = a; code = c; ann = n; fhex = h; split = s; strobe_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    strobe_n = 1'b1;
    addr = ~a; code = ~c; ann = ~n; fhex = ~h; split = ~s;
  endtask

  task automatic do_write(input string req, input logic [2:0] a, input logic [3:0] c,
                          input logic [1:0] n, input logic h, input logic s);
    pulse(a, c, n, h, s, 3);
    repeat (4) @(negedge clk);
    model[a] = expect_word(c, n, h, s);
    check(req, mem, model_flat());
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe_n = 1'b1;
    addr = '0; code = '0; ann = '0; fhex = 1'b0; split = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset clear", mem, '0);

    // R3 R4 R5 R6 R2 R8 R9: sweep code x font x placement, rotating address/ann
    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < 16; c++)
          do_write(h ? (s ? "R3 R6 R2 R8 R9 hex/split" : "R3 R5 R2 R8 R9 hex/stacked")
                     : (s ? "R4 R6 R2 R8 R9 alt/split" : "R4 R5 R2 R8 R9 alt/stacked"),
                   3'((c + 3*h + 5*s) % 8), 4'(c), 2'((c + h + s) % 4),
                   1'(h), 1'(s));

    // R7: strobe inside the busy window is dropped
    pulse(3'd2, 4'd8, 2'b11, 1'b1, 1'b0, 3);
    @(negedge clk);
    pulse(3'd2, 4'd1, 2'b00, 1'b1, 1'b0, 2);
    repeat (12) @(negedge clk);
    model[2] = expect_word(4'd8, 2'b11, 1'b1, 1'b0);
    check("R7 early strobe ignored", mem, model_flat());
    // R7: a strobe after the window lands
    do_write("R7 window reopens", 3'd2, 4'd1, 2'b00, 1'b1, 1'b0);

    // R2: every address, each write isolated
    for (int a = 0; a < 8; a++)
      do_write("R2 address isolation", 3'(a), 4'(7 - a), 2'(a), 1'b0, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule